// File: doc/BRIEF.md
# Multi-mode serial bit-rate generator

This block produces the timing strobes for one channel of a serial port. The system clock first passes through a prescaler set by a 2-bit clock-select field n. It then passes through a reload counter that runs for N+1 prescaler periods, where N is an 8-bit reload value. Together these give a basic-clock strobe every 2 x 4^n x (N+1) system clock cycles. A bit counter then groups basic strobes into one bit time. It counts 16 basic strobes in asynchronous mode, 2 in clocked synchronous mode, and S in smart card mode. S is selected from 32, 64, 372 or 256.

Each channel instantiates its own copy, so channels run at independent rates. Software loads N while the channel is stopped. While the run input is high, writes are ignored. Dropping run returns every counter to its starting point. After run is raised again, the first bit strobe comes exactly one bit time later. In synchronous mode the block also drives a serial clock level that toggles on every basic strobe, so one bit time is one full clock period.

Top module: `serial_rate_gen`

## Requirements
- R1: After reset, `rate_q` reads 0xFF and `base_tick`, `bit_tick` and `sclk_out` are 0.
- R2: When `wr_en` is high on a clock edge while `run` is low, `rate_q` shows `wr_data` from the next cycle on.
- R3: When `wr_en` is high on a clock edge while `run` is high, the write is dropped and `rate_q` keeps its value.
- R4: With `clk_sel` = n and `rate_q` = N, `base_tick` is a one-cycle pulse. It is high after enabled edge number k exactly when k is a multiple of 2 x 4^n x (N+1). Enabled edges are counted from 1, starting at the first edge that samples `run` high.
- R5: With `mode` = 2'b00 (asynchronous), `bit_tick` pulses once every 16 basic strobes. The reserved code 2'b11 behaves the same as 2'b00.
- R6: With `mode` = 2'b01 (clocked synchronous), `bit_tick` pulses once every 2 basic strobes.
- R7: In mode 2'b01, `sclk_out` starts at 0 and inverts in the same cycle that `base_tick` is high. In every other mode it stays 0.
- R8: With `mode` = 2'b10 (smart card), `bit_tick` pulses once every S basic strobes. `sc_sel` encodes S as follows: 2'b00 gives 32, 2'b01 gives 64, 2'b10 gives 372, and 2'b11 gives 256.
- R9: After an edge that samples `run` low, all three outputs are 0. When `run` is raised again, counting restarts from enabled edge 1.
- R10: `bit_tick` is high only in a cycle where `base_tick` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the reload value |
| wr_data | input | 8 | Reload value to write |
| rate_q | output | 8 | Current reload value N (readable at all times) |
| clk_sel | input | 2 | Prescaler select n (divide by 4^n) |
| mode | input | 2 | 00 asynchronous, 01 clocked synchronous, 10 smart card, 11 as 00 |
| sc_sel | input | 2 | Smart card basic clocks per bit select |
| run | input | 1 | Generator enable; low holds all counters at their start |
| base_tick | output | 1 | One-cycle basic clock strobe |
| bit_tick | output | 1 | One-cycle strobe at the end of each bit time |
| sclk_out | output | 1 | Serial clock level in synchronous mode |

## Verification
The assertions assume that `mode`, `sc_sel` and `clk_sel` change only while `run` is low. If they changed mid-run, the count of basic strobes between bit strobes would not match any single mode. The stimulus therefore reprograms these fields, and the reload value, only in a stopped window before each run is raised. It tries writes mid-run only to confirm that they are dropped. Random configurations are limited to those whose bit time is short enough to see at least one complete bit and several basic strobes in each run.

// File: rtl/srg_pkg.sv
package srg_pkg;

  localparam int RATE_W = 8;
  localparam int CSEL_W = 2;
  localparam int SEL_N  = 2 ** CSEL_W;
  // prescaler includes the fixed divide-by-two: up to 2*4^(SEL_N-1)
  localparam int PRE_W  = 2 * (SEL_N - 1) + 1;
  localparam int BIT_W  = 9;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_SCARD = 2'b10,
    MODE_RSVD  = 2'b11
  } serial_mode_e;

  // number of basic strobes in one bit time, minus one
  function automatic logic [BIT_W-1:0] bit_last(input logic [1:0] md,
                                                 input logic [1:0] sc);
    logic [BIT_W-1:0] r;
    case (md)
      MODE_SYNC:  r = BIT_W'(1);
      MODE_SCARD: begin
        case (sc)
          2'b00:   r = BIT_W'(31);
          2'b01:   r = BIT_W'(63);
          2'b10:   r = BIT_W'(371);
          default: r = BIT_W'(255);
        endcase
      end
      default:    r = BIT_W'(15);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rate_prescaler.sv
module rate_prescaler
  import srg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CSEL_W-1:0] clk_sel,
  output logic              pre_hit
);

  logic [PRE_W-1:0] term_tbl [SEL_N];
  logic [PRE_W-1:0] cnt;

  for (genvar g = 0; g < SEL_N; g++) begin : g_term
    assign term_tbl[g] = PRE_W'((2 ** (2 * g + 1)) - 1);
  end

  assign pre_hit = run && (cnt == term_tbl[clk_sel]);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (pre_hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rate_reload_counter.sv
module rate_reload_counter
  import srg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pre_hit,
  input  logic [RATE_W-1:0] reload,
  output logic              base_hit
);

  logic [RATE_W-1:0] cnt;

  assign base_hit = pre_hit && (cnt == reload);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (base_hit) begin
      cnt <= '0;
    end else if (pre_hit) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rate_bit_counter.sv
module rate_bit_counter
  import srg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       base_hit,
  input  logic [1:0] mode,
  input  logic [1:0] sc_sel,
  output logic       bit_hit
);

  logic [BIT_W-1:0] cnt;
  logic [BIT_W-1:0] last;

  assign last    = bit_last(mode, sc_sel);
  assign bit_hit = base_hit && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (bit_hit) begin
      cnt <= '0;
    end else if (base_hit) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import srg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RATE_W-1:0] wr_data,
  output logic [RATE_W-1:0] rate_q,
  input  logic [CSEL_W-1:0] clk_sel,
  input  logic [1:0]        mode,
  input  logic [1:0]        sc_sel,
  input  logic              run,
  output logic              base_tick,
  output logic              bit_tick,
  output logic              sclk_out
);

  logic pre_hit;
  logic base_hit;
  logic bit_hit;
  logic is_sync;

  assign is_sync = (mode == MODE_SYNC);

  // reload value: loaded only while stopped
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '1;
    end else if (wr_en && !run) begin
      rate_q <= wr_data;
    end
  end

  rate_prescaler u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .clk_sel (clk_sel),
    .pre_hit (pre_hit)
  );

  rate_reload_counter u_reload (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .pre_hit  (pre_hit),
    .reload   (rate_q),
    .base_hit (base_hit)
  );

  rate_bit_counter u_bit (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .base_hit (base_hit),
    .mode     (mode),
    .sc_sel   (sc_sel),
    .bit_hit  (bit_hit)
  );

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      base_tick <= 1'b0;
      bit_tick  <= 1'b0;
      sclk_out  <= 1'b0;
    end else begin
      base_tick <= base_hit;
      bit_tick  <= bit_hit;
      if (!is_sync) begin
        sclk_out <= 1'b0;
      end else if (base_hit) begin
        sclk_out <= ~sclk_out;
      end
    end
  end

endmodule

// File: rtl/srg_checker.sv
module srg_checker (
  input logic       clk,
  input logic       rst,
  input logic       run,
  input logic [1:0] mode,
  input logic [1:0] sc_sel,
  input logic [7:0] rate_q,
  input logic       base_tick,
  input logic       bit_tick,
  input logic       sclk_out
);

  logic [8:0] base_seen;
  logic [8:0] want_last;

  always_comb begin
    case (mode)
      2'b01: want_last = 9'd1;
      2'b10: begin
        case (sc_sel)
          2'b00:   want_last = 9'd31;
          2'b01:   want_last = 9'd63;
          2'b10:   want_last = 9'd371;
          default: want_last = 9'd255;
        endcase
      end
      default: want_last = 9'd15;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run || bit_tick) begin
      base_seen <= '0;
    end else if (base_tick) begin
      base_seen <= base_seen + 1'b1;
    end
  end

  AST_BIT_ON_BASE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> base_tick); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (!base_tick && !bit_tick && !sclk_out)); // R9

  AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(rate_q)); // R3

  AST_SCLK_ON_BASE: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && (sclk_out != $past(sclk_out))) |-> base_tick); // R7

  AST_SCLK_LOW_OFF_SYNC: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) != 2'b01) |-> !sclk_out); // R7

  AST_BASE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    base_tick |=> !base_tick); // R4

  AST_BIT_SPACING: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && $past(run)) |-> (base_seen == want_last)); // R5

endmodule

bind serial_rate_gen srg_checker u_srg_checker (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .mode      (mode),
  .sc_sel    (sc_sel),
  .rate_q    (rate_q),
  .base_tick (base_tick),
  .bit_tick  (bit_tick),
  .sclk_out  (sclk_out)
);

// File: tb/test_serial_rate_gen.sv
`timescale 1ns/1ps
module test_serial_rate_gen;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rate_q;
  logic [1:0] clk_sel;
  logic [1:0] mode;
  logic [1:0] sc_sel;
  logic       run;
  logic       base_tick;
  logic       bit_tick;
  logic       sclk_out;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  serial_rate_gen i_serial_rate_gen (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rate_q    (rate_q),
    .clk_sel   (clk_sel),
    .mode      (mode),
    .sc_sel    (sc_sel),
    .run       (run),
    .base_tick (base_tick),
    .bit_tick  (bit_tick),
    .sclk_out  (sclk_out)
  );

  function automatic int per_bit(input logic [1:0] md, input logic [1:0] sc);
    if (md == 2'b01) return 2;
    if (md == 2'b10) begin
      case (sc)
        2'b00:   return 32;
        2'b01:   return 64;
        2'b10:   return 372;
        default: return 256;
      endcase
    end
    return 16;
  endfunction

  function automatic int base_period(input logic [1:0] cs, input int nv);
    return 2 * (4 ** cs) * (nv + 1);
  endfunction

  function automatic string bit_req(input logic [1:0] md);
    if (md == 2'b01) return "R6";
    if (md == 2'b10) return "R8";
    return "R5";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one configured run: optional load, run for len enabled edges, mid-run write, stop
  task automatic scen(input bit do_wr, input logic [7:0] nv, input logic [1:0] md,
                      input logic [1:0] cs, input logic [1:0] sc, input int len);
    int bp, tp, cyc;
    logic [7:0] cur;
    @(negedge clk);
    run = 1'b0; mode = md; clk_sel = cs; sc_sel = sc;
    wr_en = do_wr; wr_data = nv;
    @(negedge clk);
    wr_en = 1'b0;
    cur = do_wr ? nv : rate_q;
    if (do_wr) check("R2", rate_q, nv);
    bp = base_period(cs, cur);
    tp = bp * per_bit(md, sc);
    run = 1'b1;
    cyc = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk);
      cyc++;
      #1;
      check("R4", base_tick, (cyc % bp) == 0);
      check(bit_req(md), bit_tick, (cyc % tp) == 0);
      check("R7", sclk_out, (md == 2'b01) ? ((cyc / bp) % 2) : 0);
      if (bit_tick) check("R10", base_tick, 1);
    end
    // write attempt while running must be dropped
    @(negedge clk);
    wr_en = 1'b1; wr_data = cur ^ 8'h5A;
    @(posedge clk);
    cyc++;
    #1;
    check("R4", base_tick, (cyc % bp) == 0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R3", rate_q, cur);
    run = 1'b0;
    @(posedge clk);
    #1;
    check("R9", base_tick, 0);
    check("R9", bit_tick, 0);
    check("R9", sclk_out, 0);
    check("R3", rate_q, cur);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; clk_sel = '0;
    mode = '0; sc_sel = '0; run = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", rate_q, 8'hFF);
    check("R1", base_tick, 0);
    check("R1", bit_tick, 0);
    check("R1", sclk_out, 0);

    // default reload 0xFF: base period 512
    scen(1'b0, 8'h00, 2'b00, 2'b00, 2'b00, 1100);
    // fastest cases
    scen(1'b1, 8'd0, 2'b00, 2'b00, 2'b00, 70);
    scen(1'b1, 8'd0, 2'b01, 2'b00, 2'b00, 20);
    scen(1'b1, 8'd0, 2'b11, 2'b00, 2'b00, 70);
    // every smart card factor
    scen(1'b1, 8'd0, 2'b10, 2'b00, 2'b00, 140);
    scen(1'b1, 8'd0, 2'b10, 2'b00, 2'b01, 260);
    scen(1'b1, 8'd0, 2'b10, 2'b00, 2'b10, 1500);
    scen(1'b1, 8'd0, 2'b10, 2'b00, 2'b11, 1030);
    // largest prescaler in sync mode
    scen(1'b1, 8'd1, 2'b01, 2'b11, 2'b00, 1030);
    // restart gives a full bit time again
    scen(1'b1, 8'd2, 2'b00, 2'b01, 2'b00, 400);
    scen(1'b0, 8'd2, 2'b00, 2'b01, 2'b00, 400);

    for (int k = 0; k < 24; k++) begin
      logic [7:0] nv;
      logic [1:0] md, cs, sc;
      int tp;
      do begin
        nv = 8'($urandom_range(0, 40));
        md = 2'($urandom_range(0, 3));
        cs = 2'($urandom_range(0, 2));
        sc = 2'($urandom_range(0, 3));
        tp = base_period(cs, nv) * per_bit(md, sc);
      end while (tp > 2000);
      scen(1'b1, nv, md, cs, sc, tp + 2 * base_period(cs, nv) + 3);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule